// File: doc/BRIEF.md
# Privileged Time Base and Decrementer Timer

This block is the timer unit of a processor core. It keeps a free-running 64-bit time base and a 32-bit down-counting decrementer. Both advance on one shared tick, made by dividing the processor clock by a loadable ratio N (1 to 256). Software reaches the counters through a special-register access port, which carries a register number, a read strobe, a write strobe, write data, read data and a supervisor-mode flag. Read data and the illegal-access flag appear on the cycle after the access.

The time base is read through one pair of register numbers (low half, high half) and written through a different pair. Reads are open to user mode. Writes and every decrementer access need supervisor mode. When the decrementer passes from zero to all ones, it raises a sticky exception request. The request holds until an acknowledge pulse, and the counter keeps running after the wrap.

Two small state machines carry the control. The access machine has the states ACC_IDLE, ACC_RDONE, ACC_WDONE and ACC_FAULT. Each cycle it moves to the state that classifies that cycle's access: ACC_IDLE for no access, ACC_RDONE for a legal read, ACC_WDONE for a legal write, ACC_FAULT for a refused access. The illegal flag is high only in ACC_FAULT. The exception machine has the states DEC_QUIET and DEC_PEND. It goes from DEC_QUIET to DEC_PEND on a wrap. It goes back from DEC_PEND to DEC_QUIET on an acknowledge with no wrap. Otherwise it stays where it is.

Top module: `tmr_unit`

## Requirements
- R1: After reset the time base is 0, the decrementer is 0xFFFFFFFF, the divide ratio is N=1, and dec_irq, illegal and rd_data are all 0.
- R2: A read of register 0x040 returns bits 31:0 of the time base and a read of 0x041 returns bits 63:32, in either privilege mode. The value is the one held before the access edge and appears on rd_data one cycle later.
- R3: In supervisor mode, a write to 0x048 replaces bits 31:0 of the time base and a write to 0x049 replaces bits 63:32, leaving the other half as it was. The same writes from user mode leave the time base unchanged and raise illegal on the next cycle.
- R4: The following accesses raise illegal for one cycle, change no counter and give rd_data 0: a write to a read number (0x040, 0x041), a read of a write number (0x048, 0x049), an access to any unmapped number, and read and write strobes together.
- R5: The decrementer is register 0x050 for both read and write, in supervisor mode only. A user-mode read or write of it raises illegal, returns 0 and leaves the count unchanged.
- R6: A pulse on pre_load with pre_value=V sets the ratio to N=V+1 and restarts the divider. The first tick comes N cycles after the load, and further ticks follow every N cycles.
- R7: Each tick adds one to the 64-bit time base, and the upper half increments when the lower half wraps from 0xFFFFFFFF.
- R8: Each tick subtracts one from the decrementer. A tick at count 0 loads 0xFFFFFFFF and sets dec_irq on the next cycle.
- R9: dec_irq stays high until a dec_ack pulse clears it on the next cycle. If a wrap happens in the same cycle as the acknowledge, dec_irq stays set.
- R10: A legal write that lands in the same cycle as a tick wins. The written value is stored, and the counter it targets does not advance that cycle, including the time base half that was not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Move-from special-register strobe |
| wr_en | input | 1 | Move-to special-register strobe |
| supervisor | input | 1 | High when the access is made in supervisor mode |
| spr_num | input | 10 | Special-register number of the access |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a legal read, 0 otherwise |
| illegal | output | 1 | One-cycle flag for a refused access |
| pre_load | input | 1 | Load strobe for the divide ratio |
| pre_value | input | 8 | Divide ratio minus one |
| dec_ack | input | 1 | Acknowledge of the decrementer exception |
| dec_irq | output | 1 | Sticky decrementer exception request |

## Verification
The bound checker checks on every cycle that privilege faults raise the flag, that user writes and idle cycles without a tick leave the time base unchanged, that user reads of the time base are accepted, and that the exception request is set, held and cleared as the exception machine requires. Other behaviour needs the bench's scenarios and its cycle model: the exact counts returned after long random access mixes, carry into the upper half, the spacing of ticks for loaded ratios, and a write winning over a tick in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_RDONE = 2'd1,
        ACC_WDONE = 2'd2,
        ACC_FAULT = 2'd3
    } acc_state_e;

    typedef enum logic {
        DEC_QUIET = 1'b0,
        DEC_PEND  = 1'b1
    } dec_state_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PRE_W-1:0] value,
    output logic             tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] cnt_q;

    assign tick = (cnt_q == div_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= value;
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] tb_q
);
    localparam int TB_W = 2 * DATA_W;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else if (wr_lo) begin
            tb_q[DATA_W-1:0] <= wdata;
        end else if (wr_hi) begin
            tb_q[TB_W-1:DATA_W] <= wdata;
        end else if (tick) begin
            tb_q <= tb_q + {{(TB_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/tmr_decrementer.sv
module tmr_decrementer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    output logic [DATA_W-1:0] dec_q,
    output logic              wrap,
    output logic              irq
);
    dec_state_e state_q;
    dec_state_e state_d;

    assign wrap = tick && !wr && (dec_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '1;
        end else if (wr) begin
            dec_q <= wdata;
        end else if (tick) begin
            dec_q <= dec_q - 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEC_QUIET: if (wrap) state_d = DEC_PEND;
            DEC_PEND:  if (ack && !wrap) state_d = DEC_QUIET;
            default:   state_d = DEC_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DEC_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            DEC_PEND: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_access.sv
module tmr_access
    import tmr_pkg::*;
#(
    parameter int NUM_W  = 10,
    parameter int DATA_W = 32,
    parameter logic [NUM_W-1:0] RD_LO = 10'h040,
    parameter logic [NUM_W-1:0] RD_HI = 10'h041,
    parameter logic [NUM_W-1:0] WR_LO = 10'h048,
    parameter logic [NUM_W-1:0] WR_HI = 10'h049,
    parameter logic [NUM_W-1:0] DEC_N = 10'h050
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic                supervisor,
    input  logic [NUM_W-1:0]    spr_num,
    input  logic [2*DATA_W-1:0] tb_q,
    input  logic [DATA_W-1:0]   dec_q,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic                wr_dec,
    output logic [DATA_W-1:0]   rdata,
    output logic                illegal
);
    acc_state_e        state_q;
    acc_state_e        state_d;
    logic [DATA_W-1:0] sel_val;
    logic              hit_rlo, hit_rhi, hit_wlo, hit_whi, hit_dec;

    assign hit_rlo = (spr_num == RD_LO);
    assign hit_rhi = (spr_num == RD_HI);
    assign hit_wlo = (spr_num == WR_LO);
    assign hit_whi = (spr_num == WR_HI);
    assign hit_dec = (spr_num == DEC_N);

    always_comb begin
        state_d = ACC_IDLE;
        sel_val = '0;
        wr_lo   = 1'b0;
        wr_hi   = 1'b0;
        wr_dec  = 1'b0;
        if (rd_en && wr_en) begin
            state_d = ACC_FAULT;
        end else if (rd_en) begin
            if (hit_rlo) begin
                state_d = ACC_RDONE;
                sel_val = tb_q[DATA_W-1:0];
            end else if (hit_rhi) begin
                state_d = ACC_RDONE;
                sel_val = tb_q[2*DATA_W-1:DATA_W];
            end else if (hit_dec && supervisor) begin
                state_d = ACC_RDONE;
                sel_val = dec_q;
            end else begin
                state_d = ACC_FAULT;
            end
        end else if (wr_en) begin
            if (!supervisor) begin
                state_d = ACC_FAULT;
            end else if (hit_wlo) begin
                state_d = ACC_WDONE;
                wr_lo   = 1'b1;
            end else if (hit_whi) begin
                state_d = ACC_WDONE;
                wr_hi   = 1'b1;
            end else if (hit_dec) begin
                state_d = ACC_WDONE;
                wr_dec  = 1'b1;
            end else begin
                state_d = ACC_FAULT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            rdata   <= (state_d == ACC_RDONE) ? sel_val : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_FAULT: illegal = 1'b1;
            default:   illegal = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int NUM_W  = 10,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              supervisor,
    input  logic [NUM_W-1:0]  spr_num,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              illegal,
    input  logic              pre_load,
    input  logic [PRE_W-1:0]  pre_value,
    input  logic              dec_ack,
    output logic              dec_irq
);
    localparam int TB_W = 2 * DATA_W;

    logic              tick;
    logic              wr_lo, wr_hi, wr_dec;
    logic              dec_wrap;
    logic [TB_W-1:0]   tb_q;
    logic [DATA_W-1:0] dec_q;

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pre_load),
        .value (pre_value),
        .tick  (tick)
    );

    tmr_access #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .supervisor (supervisor),
        .spr_num    (spr_num),
        .tb_q       (tb_q),
        .dec_q      (dec_q),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wr_dec     (wr_dec),
        .rdata      (rd_data),
        .illegal    (illegal)
    );

    tmr_timebase #(.DATA_W(DATA_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (wr_data),
        .tb_q  (tb_q)
    );

    tmr_decrementer #(.DATA_W(DATA_W)) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (wr_dec),
        .wdata (wr_data),
        .ack   (dec_ack),
        .dec_q (dec_q),
        .wrap  (dec_wrap),
        .irq   (dec_irq)
    );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NUM_W  = 10,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic                wr_en,
    input logic                supervisor,
    input logic [NUM_W-1:0]    spr_num,
    input logic                dec_ack,
    input logic                tick,
    input logic [2*DATA_W-1:0] tb_q,
    input logic                dec_wrap,
    input logic                dec_irq,
    input logic                illegal
);
    localparam logic [NUM_W-1:0] N_RLO = 10'h040;
    localparam logic [NUM_W-1:0] N_RHI = 10'h041;
    localparam logic [NUM_W-1:0] N_WLO = 10'h048;
    localparam logic [NUM_W-1:0] N_WHI = 10'h049;
    localparam logic [NUM_W-1:0] N_DEC = 10'h050;

    logic user_tb_wr;
    assign user_tb_wr = wr_en && !rd_en && !supervisor &&
                        (spr_num == N_WLO || spr_num == N_WHI);

    // R3
    tb_user_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_tb_wr |=> illegal);

    // R3
    tb_user_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (user_tb_wr && !tick) |=> $stable(tb_q));

    // R2
    tb_user_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (spr_num == N_RLO || spr_num == N_RHI)) |=> !illegal);

    // R5
    dec_user_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en ^ wr_en) && !supervisor && spr_num == N_DEC) |=> illegal);

    // R7
    tb_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(tb_q));

    // R8
    irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wrap |=> dec_irq);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_irq && !dec_ack) |=> dec_irq);

    // R9
    irq_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_ack && !dec_wrap) |=> !dec_irq);
endmodule

bind tmr_unit tmr_unit_chk #(.NUM_W(NUM_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .supervisor (supervisor),
    .spr_num    (spr_num),
    .dec_ack    (dec_ack),
    .tick       (tick),
    .tb_q       (tb_q),
    .dec_wrap   (dec_wrap),
    .dec_irq    (dec_irq),
    .illegal    (illegal)
);

// File: tb/tmr_unit_bench.sv
`timescale 1ns/1ps
module tmr_unit_bench;
    localparam logic [9:0] A_RLO = 10'h040;
    localparam logic [9:0] A_RHI = 10'h041;
    localparam logic [9:0] A_WLO = 10'h048;
    localparam logic [9:0] A_WHI = 10'h049;
    localparam logic [9:0] A_DEC = 10'h050;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0, wr_en = 1'b0, supervisor = 1'b0;
    logic [9:0]  spr_num = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        illegal;
    logic        pre_load = 1'b0;
    logic [7:0]  pre_value = '0;
    logic        dec_ack = 1'b0;
    logic        dec_irq;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [63:0] m_tb;
    logic [31:0] m_dec;
    logic [7:0]  m_div, m_cnt;
    logic        m_irq;

    always #2.5 clk = ~clk;

    tmr_unit u_tmr_unit (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .supervisor(supervisor), .spr_num(spr_num), .wr_data(wr_data),
        .rd_data(rd_data), .illegal(illegal), .pre_load(pre_load),
        .pre_value(pre_value), .dec_ack(dec_ack), .dec_irq(dec_irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // 0 none, 1 read ok, 2 write ok, 3 refused
    function automatic int kind(input logic rd, input logic wr, input logic sup, input logic [9:0] n);
        if (rd && wr) return 3;
        if (rd) begin
            if (n == A_RLO || n == A_RHI) return 1;
            if (n == A_DEC) return sup ? 1 : 3;
            return 3;
        end
        if (wr) begin
            if (sup && (n == A_WLO || n == A_WHI || n == A_DEC)) return 2;
            return 3;
        end
        return 0;
    endfunction

    function automatic string tag_of(input logic rd, input logic wr, input logic [9:0] n);
        if (rd && wr) return "R4";
        if (n == A_DEC) return "R5";
        if (rd && (n == A_RLO || n == A_RHI)) return "R2";
        if (wr && (n == A_WLO || n == A_WHI)) return "R3";
        return "R4";
    endfunction

    task automatic step(input logic rd, input logic wr, input logic sup, input logic [9:0] n,
                        input logic [31:0] wd, input logic ld, input logic [7:0] pv, input logic ack);
        int k;
        logic tk, wrap;
        logic [31:0] exp_rd;
        string tg;
        rd_en = rd; wr_en = wr; supervisor = sup; spr_num = n; wr_data = wd;
        pre_load = ld; pre_value = pv; dec_ack = ack;
        k  = kind(rd, wr, sup, n);
        tg = tag_of(rd, wr, n);
        tk = (m_cnt == m_div);
        exp_rd = '0;
        if (k == 1) begin
            if (n == A_RLO)      exp_rd = m_tb[31:0];
            else if (n == A_RHI) exp_rd = m_tb[63:32];
            else                 exp_rd = m_dec;
        end
        wrap = 1'b0;
        if (k == 2 && n == A_WLO)      m_tb[31:0]  = wd;
        else if (k == 2 && n == A_WHI) m_tb[63:32] = wd;
        else if (tk)                   m_tb = m_tb + 64'd1;
        if (k == 2 && n == A_DEC) m_dec = wd;
        else if (tk) begin
            wrap  = (m_dec == 32'd0);
            m_dec = m_dec - 32'd1;
        end
        if (wrap)     m_irq = 1'b1;
        else if (ack) m_irq = 1'b0;
        if (ld) begin m_div = pv; m_cnt = 8'd0; end
        else if (tk) m_cnt = 8'd0;
        else m_cnt = m_cnt + 8'd1;
        @(posedge clk);
        @(negedge clk);
        check({tg, " illegal"}, 64'(illegal), 64'(k == 3));
        check({tg, " rd_data"}, 64'(rd_data), 64'(exp_rd));
        check("R9 dec_irq", 64'(dec_irq), 64'(m_irq));
        rd_en = 0; wr_en = 0; pre_load = 0; dec_ack = 0;
    endtask

    task automatic idle(input int cyc);
        for (int i = 0; i < cyc; i++) step(0, 0, 0, '0, '0, 0, '0, 0);
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_tb = '0; m_dec = '1; m_div = '0; m_cnt = '0; m_irq = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rd_data", 64'(rd_data), 64'd0);
        check("R1 illegal", 64'(illegal), 64'd0);
        check("R1 dec_irq", 64'(dec_irq), 64'd0);
        step(1, 0, 0, A_RLO, '0, 0, '0, 0);
        check("R1 tb low at reset", 64'(rd_data), 64'd0);
        step(1, 0, 1, A_DEC, '0, 0, '0, 0);
        check("R1 dec after one tick", 64'(rd_data), 64'hFFFF_FFFE);

        // R6 divide by 3
        step(0, 1, 1, A_WLO, 32'd0, 1, 8'd2, 0);
        idle(9);
        step(1, 0, 0, A_RLO, '0, 0, '0, 0);
        check("R6 three ticks in nine cycles", 64'(rd_data), 64'd3);

        // R7 carry, R10 write beats tick
        step(0, 0, 0, '0, '0, 1, 8'd0, 0);
        step(0, 1, 1, A_WLO, 32'hFFFF_FFFE, 0, '0, 0);
        step(0, 1, 1, A_WHI, 32'd5, 0, '0, 0);
        step(1, 0, 1, A_RLO, '0, 0, '0, 0);
        check("R10 low write wins tick", 64'(rd_data), 64'hFFFF_FFFE);
        step(1, 0, 0, A_RHI, '0, 0, '0, 0);
        check("R7 upper before carry", 64'(rd_data), 64'd5);
        step(1, 0, 0, A_RHI, '0, 0, '0, 0);
        check("R7 upper after carry", 64'(rd_data), 64'd6);
        step(1, 0, 0, A_RLO, '0, 0, '0, 0);
        check("R7 lower after carry", 64'(rd_data), 64'd1);

        // R3 user write refused
        step(0, 1, 0, A_WHI, 32'hDEAD, 0, '0, 0);
        check("R3 user write flagged", 64'(illegal), 64'd1);
        step(1, 0, 0, A_RHI, '0, 0, '0, 0);
        check("R3 upper unchanged", 64'(rd_data), 64'd6);

        // R4 odd accesses
        step(0, 1, 1, A_RLO, 32'd7, 0, '0, 0);
        check("R4 write to read number", 64'(illegal), 64'd1);
        step(1, 0, 1, A_WLO, '0, 0, '0, 0);
        check("R4 read of write number", 64'(illegal), 64'd1);
        step(1, 1, 1, A_DEC, 32'd9, 0, '0, 0);
        check("R4 both strobes", 64'(illegal), 64'd1);

        // R5 user decrementer access
        step(1, 0, 0, A_DEC, '0, 0, '0, 0);
        check("R5 user dec read zero", 64'(rd_data), 64'd0);

        // R8 wrap, R9 sticky and ack
        step(0, 1, 1, A_DEC, 32'd2, 0, '0, 0);
        idle(2);
        check("R8 no irq at zero", 64'(dec_irq), 64'd0);
        idle(1);
        check("R8 irq after wrap", 64'(dec_irq), 64'd1);
        step(1, 0, 1, A_DEC, '0, 0, '0, 0);
        check("R8 counter runs on", 64'(rd_data), 64'hFFFF_FFFF);
        idle(5);
        check("R9 irq held", 64'(dec_irq), 64'd1);
        step(0, 0, 0, '0, '0, 0, '0, 1);
        check("R9 ack clears", 64'(dec_irq), 64'd0);
        step(0, 1, 1, A_DEC, 32'd0, 0, '0, 0);
        step(0, 0, 0, '0, '0, 0, '0, 1);
        check("R9 wrap beats ack", 64'(dec_irq), 64'd1);
        step(0, 0, 0, '0, '0, 0, '0, 1);

        // R6 ratio 256
        step(0, 1, 1, A_WLO, 32'd0, 1, 8'd255, 0);
        idle(511);
        step(1, 0, 0, A_RLO, '0, 0, '0, 0);
        check("R6 divide by 256", 64'(rd_data), 64'd1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [9:0] n;
            int sel;
            logic [31:0] wd;
            sel = $urandom_range(0, 7);
            case (sel)
                0: n = A_RLO; 1: n = A_RHI; 2: n = A_WLO; 3: n = A_WHI;
                4, 5: n = A_DEC;
                default: n = 10'($urandom_range(0, 127));
            endcase
            wd = ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 6)) : $urandom;
            step($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) != 0, n, wd,
                 $urandom_range(0, 60) == 0, 8'($urandom_range(0, 4)),
                 $urandom_range(0, 9) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule